// File: doc/BRIEF.md
# Two-Wire Serial Byte Store Slave

This block is a slave on a two-wire serial bus (clock plus open-drain data). It sits in front of a 256-byte store held in an on-chip register array. It watches synchronised copies of the bus clock and data lines and acknowledges its own device byte. The device byte carries a fixed 4-bit family code followed by three strap bits. After that it accepts a word address and data bytes for writing, or sends stored bytes back for reading. The block drives the data line only through an active-high pull-low enable.

A write does not go straight to the store. Its bytes are staged in a one-page buffer, with a page of 16 bytes by default. They are committed only when the master ends the transfer cleanly with a stop. After a commit, the block stays deaf to the bus for a programmable number of system clocks, so a master finds out that the write has finished by polling the device address until an acknowledge comes back. Which addresses may be written is decided outside the block: the block presents the target address on `chk_addr_o`, and the enclosing logic answers on `chk_allow_i`.

One address pointer is shared by reads and writes. Reads advance the whole pointer and wrap from FFh to 00h. Writes step only the low part of the pointer, so a page write wraps inside its page.

Top module: `tw_store_slave`

## Requirements
- R1: A start condition (data falling while clock is high) at any point cancels the current command and begins device-byte reception. A stop (data rising while clock is high) returns the block to idle with the data line released.
- R2: The device byte is acknowledged only when its upper four bits are 1010 and bits 3..1 equal `strap_i`. Bit 0 selects read (1) or write (0). Any other device byte gets no acknowledge.
- R3: A byte write to an allowed address is acknowledged. The byte is stored when a stop follows directly after the data acknowledge, and a later read returns it.
- R4: Within a write, each accepted data byte advances only the low 4 pointer bits. The upper bits are unchanged, so byte 17 onward overwrites the earliest bytes of the same page.
- R5: A stop that arrives part-way through a data byte discards the whole write. Nothing is stored and no busy interval starts.
- R6: A write command carrying only a word address loads the pointer, stores nothing and starts no busy interval. A repeated start plus read then returns the byte at that address.
- R7: A read command with no word address returns the byte at the current pointer and advances the pointer by one.
- R8: In a read, each master acknowledge makes the block send the next byte. The pointer wraps from FFh to 00h, and a master no-acknowledge ends the read.
- R9: For WRITE_CYCLES system clocks after a committing stop, the block acknowledges nothing, its own device byte included. After that interval it acknowledges again.
- R10: A data byte whose address sees `chk_allow_i` low is not acknowledged and nothing from that command is stored.
- R11: After reset the data line is released and the pointer is 00h. Cells never written read as FFh.
- R12: The data line changes only while the bus clock is low. The acknowledge is held from the falling edge after bit 8 to the falling edge after bit 9, and then released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level (oversampled) |
| sda_i | input | 1 | Bus data level as seen on the wire |
| strap_i | input | 3 | Board-strapped slave address bits |
| chk_allow_i | input | 1 | High when the address on `chk_addr_o` may be written |
| chk_addr_o | output | 8 | Current pointer, the target of the next data byte |
| sda_pull_o | output | 1 | High pulls the data line low |

## Verification
A wrong pointer shows up within one byte time as wrong read data or a wrong `chk_addr_o`, and the wrap cases at the page edge and at FFh expose a pointer that advances the wrong bits. A wrong bit count or phase shows as an acknowledge that is missing or shifted by one clock. It can also show as a stop that commits a write when it should discard it, or discards one it should commit. That becomes visible in the next read-back, and also in whether the following device poll is acknowledged. A busy timer that is too short or too long shows on the first poll after the write.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } tw_state_t;
endpackage

// File: rtl/tw_bus_sense.sv
module tw_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_lvl
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_q, sda_q;
  logic          scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[LAST-1:0], scl_i};
      sda_q <= {sda_q[LAST-1:0], sda_i};
      scl_p <= scl_q[LAST];
      sda_p <= sda_q[LAST];
    end
  end

  assign sda_lvl  = sda_q[LAST];
  assign scl_rise = scl_q[LAST] & ~scl_p;
  assign scl_fall = ~scl_q[LAST] & scl_p;
  assign start_ev = scl_q[LAST] & scl_p & sda_p & ~sda_q[LAST];
  assign stop_ev  = scl_q[LAST] & scl_p & ~sda_p & sda_q[LAST];
endmodule

// File: rtl/tw_store_mem.sv
module tw_store_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/tw_busy_timer.sv
module tw_busy_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] C_LOAD = CW'(CYCLES);
  localparam logic [CW-1:0] C_ONE  = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= C_LOAD;
    else if (cnt != '0)   cnt <= cnt - C_ONE;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/tw_store_slave.sv
module tw_store_slave
  import tw_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          PAGE_W       = 4,
  parameter int          WRITE_CYCLES = 5000,
  parameter int          SYNC_STAGES  = 2,
  parameter logic [3:0]  DEV_CODE     = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              chk_allow_i,
  output logic [ADDR_W-1:0] chk_addr_o,
  output logic              sda_pull_o
);
  localparam int BYTE_W = 8;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [PAGE_W-1:0] P_ONE = PAGE_W'(1);
  localparam logic [PAGE_W-1:0] P_LAST = PAGE_W'(PAGE_N - 1);

  logic scl_rise, scl_fall, start_ev, stop_ev, sda_lvl;

  tw_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_lvl(sda_lvl)
  );

  tw_state_t          state;
  logic [3:0]         bitc;
  logic [BYTE_W-1:0]  rx_sr, tx_sr;
  logic [ADDR_W-1:0]  ptr;
  logic               mack;
  logic [PAGE_N-1:0]  pmask;
  logic               commit_go;
  logic               tmr_busy, busy;

  // commit engine
  logic               wact;
  logic [PAGE_W-1:0]  widx;
  logic [HI_W-1:0]    wbase;
  logic [BYTE_W-1:0]  pbuf [PAGE_N];
  logic               mem_we;
  logic [BYTE_W-1:0]  rd_data;

  tw_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .load(commit_go), .busy(tmr_busy)
  );

  assign busy   = tmr_busy | wact;
  assign mem_we = wact & pmask[widx];

  tw_store_mem #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr({wbase, widx}), .wdata(pbuf[widx]),
    .raddr(ptr), .rdata(rd_data)
  );

  logic rx_state, ack_ok, ack_slot, end_slot, stage_we;

  assign rx_state = (state == ST_DEV) || (state == ST_WADDR) || (state == ST_WDATA);
  assign ack_slot = scl_fall && (bitc == 4'd8);
  assign end_slot = scl_fall && (bitc == 4'd9);

  always_comb begin
    unique case (state)
      ST_DEV:   ack_ok = (rx_sr[7:4] == DEV_CODE) && (rx_sr[3:1] == strap_i);
      ST_WADDR: ack_ok = 1'b1;
      ST_WDATA: ack_ok = chk_allow_i;
      default:  ack_ok = 1'b0;
    endcase
  end

  assign stage_we = !busy && !start_ev && !stop_ev && (state == ST_WDATA) &&
                    ack_slot && chk_allow_i;

  always_ff @(posedge clk) begin
    if (stage_we) pbuf[ptr[PAGE_W-1:0]] <= rx_sr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bitc       <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      ptr        <= '0;
      mack       <= 1'b0;
      pmask      <= '0;
      sda_pull_o <= 1'b0;
      commit_go  <= 1'b0;
    end else begin
      commit_go <= 1'b0;
      if (busy) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_ev) begin
        state      <= ST_DEV;
        bitc       <= '0;
        pmask      <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_ev) begin
        // the clock rise ahead of a stop counts as bit one
        if (state == ST_WDATA && bitc == 4'd1 && pmask != '0) commit_go <= 1'b1;
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise && bitc < 4'd9) begin
          bitc <= bitc + 4'd1;
          if (bitc < 4'd8) rx_sr <= {rx_sr[BYTE_W-2:0], sda_lvl};
        end
        if (ack_slot) begin
          sda_pull_o <= ack_ok;
          if (!ack_ok) state <= ST_IDLE;
          else if (state == ST_WADDR) ptr <= rx_sr[ADDR_W-1:0];
          else if (state == ST_WDATA) begin
            pmask[ptr[PAGE_W-1:0]] <= 1'b1;
            ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + P_ONE};
          end
        end
        if (end_slot) begin
          bitc <= '0;
          sda_pull_o <= 1'b0;
          if (state == ST_DEV && rx_sr[0]) begin
            state      <= ST_RDATA;
            tx_sr      <= rd_data;
            sda_pull_o <= ~rd_data[BYTE_W-1];
          end else if (state == ST_DEV) begin
            state <= ST_WADDR;
          end else begin
            state <= ST_WDATA;
          end
        end
      end else if (state == ST_RDATA) begin
        if (scl_rise && bitc < 4'd9) begin
          bitc <= bitc + 4'd1;
          if (bitc == 4'd8) mack <= ~sda_lvl;
        end
        if (scl_fall) begin
          if (bitc >= 4'd1 && bitc <= 4'd7) begin
            tx_sr      <= {tx_sr[BYTE_W-2:0], 1'b0};
            sda_pull_o <= ~tx_sr[BYTE_W-2];
          end else if (bitc == 4'd8) begin
            sda_pull_o <= 1'b0;
            ptr        <= ptr + A_ONE;
          end else if (bitc == 4'd9) begin
            bitc <= '0;
            if (mack) begin
              tx_sr      <= rd_data;
              sda_pull_o <= ~rd_data[BYTE_W-1];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wact  <= 1'b0;
      widx  <= '0;
      wbase <= '0;
    end else if (commit_go) begin
      wact  <= 1'b1;
      widx  <= '0;
      wbase <= ptr[ADDR_W-1:PAGE_W];
    end else if (wact) begin
      widx <= widx + P_ONE;
      if (widx == P_LAST) wact <= 1'b0;
    end
  end

  assign chk_addr_o = ptr;
endmodule

// File: rtl/tw_store_chk.sv
module tw_store_chk
  import tw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_pull_o,
  input logic [ADDR_W-1:0] chk_addr_o,
  input tw_state_t         state,
  input logic              busy,
  input logic              mem_we
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |-> !sda_pull_o);

  p_store_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  p_page_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WDATA && $past(state) == ST_WDATA)
      |-> chk_addr_o[ADDR_W-1:PAGE_W] == $past(chk_addr_o[ADDR_W-1:PAGE_W]));

  p_read_step_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDATA && $past(state) == ST_RDATA && chk_addr_o != $past(chk_addr_o))
      |-> chk_addr_o == ADDR_W'($past(chk_addr_o) + ADDR_W'(1)));

  p_deaf_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> (state == ST_IDLE && !sda_pull_o));

  p_pull_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> !scl_i);
endmodule

bind tw_store_slave tw_store_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .chk_addr_o(chk_addr_o), .state(state), .busy(busy), .mem_we(mem_we)
);

// File: tb/test_tw_store_slave.sv
module test_tw_store_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam int WCYC = 400;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  // {is_read, addr, data or expected}
  localparam logic [16:0] VEC [9] = '{
    {1'b0, 8'h24, 8'hA5}, {1'b0, 8'h25, 8'h3C}, {1'b0, 8'h80, 8'h00},
    {1'b0, 8'hFF, 8'h77}, {1'b1, 8'h24, 8'hA5}, {1'b1, 8'h25, 8'h3C},
    {1'b1, 8'h80, 8'h00}, {1'b1, 8'hFF, 8'h77}, {1'b1, 8'h9A, 8'hFF}
  };

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, sda_bus, allow;
  logic [7:0] paddr;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] wbuf [32];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;
  assign allow   = (paddr[7:5] != 3'b000);

  tw_store_slave #(.WRITE_CYCLES(WCYC)) i_tw_store_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(STRAP),
    .chk_allow_i(allow), .chk_addr_o(paddr), .sda_pull_o(sda_pull)
  );

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i >= 8 - n; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); acked = ~sda_bus; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; wq(Q); scl_m = 1; wq(Q); b[i] = sda_bus; wq(Q); scl_m = 0; wq(Q);
    end
    sda_m = ~give_ack; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q); sda_m = 1;
  endtask

  task automatic wait_ready;
    logic a;
    for (int t = 0; t < 100; t++) begin
      bus_start; send_byte(DEV_W, a); bus_stop;
      if (a) break;
    end
  endtask

  task automatic do_write(input logic [7:0] addr, input int n, output logic all_ack);
    logic a;
    bus_start;
    send_byte(DEV_W, a); all_ack = a;
    send_byte(addr, a);  all_ack &= a;
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], a); all_ack &= a; end
    bus_stop;
  endtask

  task automatic rd_rand(input logic [7:0] addr, output logic [7:0] b);
    logic a;
    bus_start; send_byte(DEV_W, a); send_byte(addr, a);
    bus_start; send_byte(DEV_R, a); recv_byte(1'b0, b); bus_stop;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic a, ok;
    logic [7:0] b;
    wq(10); rst = 0; wq(5);
    chk("R11 reset release", sda_pull, 1'b0);
    chk("R11 reset pointer", paddr, 8'h00);
    bus_start; send_byte(DEV_R, a); recv_byte(1'b0, b); bus_stop;
    chk("R11 current read ack", a, 1'b1);
    chk("R11 blank cell FF", b, 8'hFF);
    chk("R7 pointer advanced", paddr, 8'h01);

    // table walk: byte writes then read-backs
    for (int v = 0; v < 9; v++) begin
      if (!VEC[v][16]) begin
        wbuf[0] = VEC[v][7:0];
        do_write(VEC[v][15:8], 1, ok);
        chk("R3 write acks", ok, 1'b1);
        wait_ready;
      end else begin
        rd_rand(VEC[v][15:8], b);
        chk("R3 read back", b, VEC[v][7:0]);
      end
    end

    // R2 address match
    bus_start; send_byte({4'b1010, 3'b100, 1'b0}, a); bus_stop;
    chk("R2 strap mismatch nack", a, 1'b0);
    bus_start; send_byte({4'b0110, STRAP, 1'b0}, a); bus_stop;
    chk("R2 code mismatch nack", a, 1'b0);
    bus_start; send_byte(DEV_W, a);
    chk("R2 match ack", a, 1'b1);
    chk("R12 ack released after 9th clock", sda_pull, 1'b0);
    bus_stop;

    // R1 restart mid-byte
    bus_start; send_byte(DEV_W, a); send_byte(8'h24, a); send_bits(8'hFF, 3);
    bus_start; send_byte(DEV_R, a); recv_byte(1'b0, b); bus_stop;
    chk("R1 restart ack", a, 1'b1);
    chk("R1 restart data", b, 8'hA5);

    // R5 stop mid-byte discards
    bus_start; send_byte(DEV_W, a); send_byte(8'h33, a); send_byte(8'h11, a);
    send_bits(8'h00, 3); bus_stop;
    bus_start; send_byte(DEV_W, a); bus_stop;
    chk("R5 no busy after discard", a, 1'b1);
    rd_rand(8'h33, b);
    chk("R5 cell untouched", b, 8'hFF);

    // R6 dummy write then immediate ack
    rd_rand(8'h25, b);
    chk("R6 random read", b, 8'h3C);
    bus_start; send_byte(DEV_W, a); bus_stop;
    chk("R6 no busy after dummy write", a, 1'b1);

    // R9 busy window
    wbuf[0] = 8'h5E; do_write(8'h90, 1, ok);
    bus_start; send_byte(DEV_W, a); bus_stop;
    chk("R9 nack while busy", a, 1'b0);
    wq(WCYC + 50);
    bus_start; send_byte(DEV_R, a); recv_byte(1'b0, b); bus_stop;
    chk("R9 ack after busy", a, 1'b1);

    // R4 page wrap in page
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    do_write(8'h4E, 3, ok); wait_ready;
    rd_rand(8'h40, b); chk("R4 wrap to page start", b, 8'hA3);
    rd_rand(8'h50, b); chk("R4 next page untouched", b, 8'hFF);
    rd_rand(8'h4E, b); chk("R4 first byte", b, 8'hA1);
    bus_start; send_byte(DEV_R, a); recv_byte(1'b0, b); bus_stop;
    chk("R7 current address read", b, 8'hA2);

    // R4 overflow overwrites
    for (int i = 0; i < 18; i++) wbuf[i] = 8'hC0 + 8'(i);
    do_write(8'h60, 18, ok); wait_ready;
    rd_rand(8'h60, b); chk("R4 overwrite 60", b, 8'hD0);
    rd_rand(8'h61, b); chk("R4 overwrite 61", b, 8'hD1);
    rd_rand(8'h62, b); chk("R4 kept 62", b, 8'hC2);

    // R8 sequential with wrap
    wbuf[0] = 8'hE1; do_write(8'hFE, 1, ok); wait_ready;
    bus_start; send_byte(DEV_W, a); send_byte(8'hFE, a);
    bus_start; send_byte(DEV_R, a);
    recv_byte(1'b1, b); chk("R8 seq FE", b, 8'hE1);
    recv_byte(1'b1, b); chk("R8 seq FF", b, 8'h77);
    recv_byte(1'b1, b); chk("R8 seq wrap 00", b, 8'hFF);
    recv_byte(1'b0, b); chk("R8 seq 01", b, 8'hFF);
    bus_stop;
    chk("R8 pointer after nack", paddr, 8'h02);

    // R10 write disallowed
    wbuf[0] = 8'h5A; do_write(8'h05, 1, ok);
    chk("R10 data nack", ok, 1'b0);
    bus_start; send_byte(DEV_W, a); bus_stop;
    chk("R10 no busy", a, 1'b1);
    rd_rand(8'h05, b);
    chk("R10 cell untouched", b, 8'hFF);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule